// File: doc/BRIEF.md
# Bus-Start-Refreshed Watchdog Timer

This block is a watchdog that takes its keep-alive from the traffic on a two-wire serial bus, so no separate kick pin is needed. It samples the bus clock and data lines through a two-stage synchronizer. It treats every START condition, which is data falling while the clock line is high, as a refresh. If no refresh arrives within the selected period, an active-low reset output goes low for a fixed number of millisecond ticks. The watchdog then reloads and starts counting again.

All timing advances only on a one-cycle `tick_1ms` enable, so the periods do not depend on the system clock frequency. A two-bit select field chooses one of three periods, or turns the watchdog off. In the off setting the counter is frozen so that it does not toggle. A battery-mode input also disables the watchdog and releases the reset output. The controller is a three-state machine:
- **ST_IDLE**: disabled.
- **ST_COUNT**: counting down toward expiry.
- **ST_PULSE**: the reset pulse is being driven.

The transitions are:
- **enable**: IDLE to COUNT, loading the selected period.
- **expire**: COUNT to PULSE, on the tick that finds the count at 1.
- **release**: PULSE to COUNT, on the tick that ends the pulse, reloading the period.
- **disable**: any state to IDLE, when battery mode is on or the select field is 11.

Top module: `bus_watchdog`

## Requirements
- R1: After `rst_n` is released, `wd_rst_n` is high and the bus lines are treated as idle-high, so no START is seen.
- R2: A START (synchronized SDA falling while synchronized SCL is high) in ST_COUNT reloads the counter to the full selected period. SDA and SCL pass through two flops, so the reload happens on the third clock edge after the lines change. A START takes priority over a tick that arrives in the same cycle.
- R3: The select encoding is: `wd_sel` = 00 gives 1750 ticks, 01 gives 750 ticks, 10 gives 250 ticks, and 11 turns the watchdog off. After a load, `wd_rst_n` goes low on exactly the period-th tick that has no START.
- R4: The reset pulse keeps `wd_rst_n` low for exactly 250 ticks.
- R5: A START during the reset pulse changes neither the pulse length nor the count.
- R6: Battery mode (`batt_mode`=1) or `wd_sel`=11 sends the block to ST_IDLE on the next clock edge. In ST_IDLE `wd_rst_n` is high and the counter holds its value. Leaving ST_IDLE loads the full selected period.
- R7: When the pulse ends, the counter reloads the full selected period and counting resumes.
- R8: A change of `wd_sel` in ST_COUNT reloads the counter with the new period on the next clock edge.
- R9: SDA falling while SCL is low, and SDA rising while SCL is high (a STOP), do not refresh the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line sample (asynchronous) |
| sda_in | input | 1 | Bus data line sample (asynchronous) |
| tick_1ms | input | 1 | One-cycle millisecond enable |
| batt_mode | input | 1 | High while running on battery; disables the watchdog |
| wd_sel | input | 2 | Period select: 00=1750, 01=750, 10=250 ticks, 11=off |
| wd_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
The refresh and the expiry can fall in the same cycle. This happens when a START is decoded on the very tick that would take the count from 1 to expiry. The bench brings the count to 1 and then lowers SDA with SCL high. It times the single tick pulse so that the tick lands in the cycle where the synchronized START is decoded, two edges after the line change. The collision is judged correct if `wd_rst_n` stays high and the next pulse comes only after a full further period. A pulse there, or a shortened period, would show that the expiry had beaten the refresh.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } wdg_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else begin
                    if (g == 0) begin
                        chain[g] <= d_in;
                    end else begin
                        chain[g] <= chain[(g == 0) ? 0 : g-1];
                    end
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/wdg_start_det.sv
module wdg_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_evt
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // data falls while the clock line stays high across both samples
    assign start_evt = scl_p & scl_s & sda_p & ~sda_s;

endmodule

// File: rtl/wdg_downcnt.sv
module wdg_downcnt #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          at_one
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_one = (cnt == CW'(1));

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import wdg_pkg::*;
#(
    parameter int TICKS_LONG  = 1750,
    parameter int TICKS_MID   = 750,
    parameter int TICKS_SHORT = 250,
    parameter int PULSE_TICKS = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       tick_1ms,
    input  logic       batt_mode,
    input  logic [1:0] wd_sel,
    output logic       wd_rst_n
);

    localparam int MAX_A = (TICKS_LONG > TICKS_MID) ? TICKS_LONG : TICKS_MID;
    localparam int MAX_B = (TICKS_SHORT > PULSE_TICKS) ? TICKS_SHORT : PULSE_TICKS;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_T + 1);

    logic [1:0]    bus_s;
    logic          start_evt;
    logic          enabled;
    logic          sel_chg;
    logic [1:0]    sel_q;
    logic [CW-1:0] period;
    logic [CW-1:0] cnt;
    logic          at_one;
    logic          ld;
    logic          dec;
    logic [CW-1:0] ld_val;
    wdg_state_e    state_q;
    wdg_state_e    state_d;

    wdg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (bus_s)
    );

    wdg_start_det u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .start_evt (start_evt)
    );

    wdg_downcnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .dec      (dec),
        .cnt      (cnt),
        .at_one   (at_one)
    );

    always_comb begin
        unique case (wd_sel)
            SEL_LONG:  period = CW'(TICKS_LONG);
            SEL_MID:   period = CW'(TICKS_MID);
            SEL_SHORT: period = CW'(TICKS_SHORT);
            default:   period = CW'(TICKS_SHORT);
        endcase
    end

    assign enabled = !batt_mode && (wd_sel != SEL_OFF);
    assign sel_chg = (wd_sel != sel_q);

    // next state and counter control
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        dec     = 1'b0;
        ld_val  = period;
        unique case (state_q)
            ST_IDLE: begin
                if (enabled) begin
                    state_d = ST_COUNT;
                    ld      = 1'b1;
                end
            end
            ST_COUNT: begin
                if (!enabled) begin
                    state_d = ST_IDLE;
                end else if (start_evt || sel_chg) begin
                    ld = 1'b1;
                end else if (tick_1ms) begin
                    if (at_one) begin
                        state_d = ST_PULSE;
                        ld      = 1'b1;
                        ld_val  = CW'(PULSE_TICKS);
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            ST_PULSE: begin
                if (!enabled) begin
                    state_d = ST_IDLE;
                end else if (tick_1ms) begin
                    if (at_one) begin
                        state_d = ST_COUNT;
                        ld      = 1'b1;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= SEL_OFF;
        end else begin
            state_q <= state_d;
            sel_q   <= wd_sel;
        end
    end

    // outputs
    always_comb begin
        wd_rst_n = (state_q != ST_PULSE);
    end

endmodule

// File: rtl/bus_watchdog_chk.sv
module bus_watchdog_chk
    import wdg_pkg::*;
#(
    parameter int TICKS_LONG  = 1750,
    parameter int TICKS_MID   = 750,
    parameter int TICKS_SHORT = 250,
    parameter int PULSE_TICKS = 250,
    parameter int CW          = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_1ms,
    input logic          batt_mode,
    input logic [1:0]    wd_sel,
    input logic          wd_rst_n,
    input logic          start_evt,
    input wdg_state_e    state_q,
    input logic [CW-1:0] cnt
);

    logic          dis;
    logic [CW-1:0] exp_period;

    assign dis = batt_mode || (wd_sel == 2'b11);
    assign exp_period = (wd_sel == 2'b00) ? CW'(TICKS_LONG) :
                        (wd_sel == 2'b01) ? CW'(TICKS_MID)  : CW'(TICKS_SHORT);

    // R6: disabling forces the reset output high on the next edge
    p_dis_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> wd_rst_n);

    // R6: counter frozen while idle
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> $stable(cnt));

    // R2: START in counting state reloads the full period
    p_start_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && start_evt && !dis) |=> (cnt == $past(exp_period) && wd_rst_n));

    // R5: START during the pulse changes nothing
    p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && start_evt && !tick_1ms && !dis) |=>
            (state_q == ST_PULSE && $stable(cnt)));

    // R3: the pulse begins only on a tick
    p_pulse_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |-> $past(tick_1ms));

    // R4: the pulse starts with the full pulse length loaded
    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |-> (cnt == CW'(PULSE_TICKS)));

endmodule

bind bus_watchdog bus_watchdog_chk #(
    .TICKS_LONG  (TICKS_LONG),
    .TICKS_MID   (TICKS_MID),
    .TICKS_SHORT (TICKS_SHORT),
    .PULSE_TICKS (PULSE_TICKS),
    .CW          (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1ms  (tick_1ms),
    .batt_mode (batt_mode),
    .wd_sel    (wd_sel),
    .wd_rst_n  (wd_rst_n),
    .start_evt (start_evt),
    .state_q   (state_q),
    .cnt       (cnt)
);

// File: tb/sim_bus_watchdog.sv
`timescale 1ns/1ps
module sim_bus_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       tick_1ms = 1'b0;
    logic       batt_mode = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic       wd_rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_watchdog u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .tick_1ms  (tick_1ms),
        .batt_mode (batt_mode),
        .wd_sel    (wd_sel),
        .wd_rst_n  (wd_rst_n)
    );

    task automatic check_out(input logic exp, input string req);
        n_chk++;
        if (wd_rst_n !== exp) begin
            n_fail++;
            $display("FAIL %s: wd_rst_n actual %b expected %b at %0t", req, wd_rst_n, exp, $time);
        end
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_1ms = 1'b1;
        repeat (n) @(negedge clk);
        tick_1ms = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        @(negedge clk);
        sda_in = 1'b0;
        idle_cycles(3);
        scl_in = 1'b0;
        idle_cycles(1);
        sda_in = 1'b1;
        idle_cycles(1);
        scl_in = 1'b1;
        idle_cycles(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle_cycles(3);
        check_out(1'b1, "R1 in reset");
        rst_n = 1'b1;
        idle_cycles(3);
        check_out(1'b1, "R1 after reset");
    endtask

    task automatic t_long_and_pulse();
        run_ticks(1749);
        check_out(1'b1, "R3 long period not yet");
        run_ticks(1);
        check_out(1'b0, "R3 long period expiry");
        run_ticks(249);
        check_out(1'b0, "R4 pulse still low");
        run_ticks(1);
        check_out(1'b1, "R4 pulse ends at 250");
        run_ticks(1749);
        check_out(1'b1, "R7 reload after pulse");
        run_ticks(1);
        check_out(1'b0, "R7 next expiry full period");
        run_ticks(250);
        check_out(1'b1, "R4 second pulse end");
    endtask

    task automatic t_sel(input logic [1:0] s, input int p, input string req);
        @(negedge clk);
        wd_sel = s;
        idle_cycles(2);
        run_ticks(p - 1);
        check_out(1'b1, req);
        run_ticks(1);
        check_out(1'b0, req);
        run_ticks(250);
        check_out(1'b1, req);
    endtask

    task automatic t_sel_change();
        @(negedge clk);
        wd_sel = 2'b00;
        idle_cycles(2);
        run_ticks(1000);
        wd_sel = 2'b10;
        idle_cycles(2);
        run_ticks(249);
        check_out(1'b1, "R8 reload on select change");
        run_ticks(1);
        check_out(1'b0, "R8 new period expiry");
        run_ticks(250);
    endtask

    task automatic t_refresh();
        run_ticks(200);
        bus_start();
        run_ticks(249);
        check_out(1'b1, "R2 refreshed count");
        run_ticks(1);
        check_out(1'b0, "R2 expiry after refresh");
        run_ticks(250);
    endtask

    task automatic t_start_in_pulse();
        run_ticks(250);
        check_out(1'b0, "R5 pulse begun");
        run_ticks(100);
        bus_start();
        run_ticks(149);
        check_out(1'b0, "R5 pulse not disturbed");
        run_ticks(1);
        check_out(1'b1, "R5 pulse length kept");
    endtask

    task automatic t_not_start();
        run_ticks(100);
        @(negedge clk);
        scl_in = 1'b0;
        idle_cycles(1);
        sda_in = 1'b0;
        idle_cycles(1);
        scl_in = 1'b1;
        idle_cycles(3);
        sda_in = 1'b1;
        idle_cycles(3);
        run_ticks(149);
        check_out(1'b1, "R9 no refresh yet");
        run_ticks(1);
        check_out(1'b0, "R9 fall with clock low or stop did not refresh");
        run_ticks(250);
    endtask

    task automatic t_coincide();
        run_ticks(249);
        @(negedge clk);
        sda_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        check_out(1'b1, "R2 start beats expiry tick");
        scl_in = 1'b0;
        idle_cycles(1);
        sda_in = 1'b1;
        idle_cycles(1);
        scl_in = 1'b1;
        idle_cycles(3);
        run_ticks(249);
        check_out(1'b1, "R2 full period after collision");
        run_ticks(1);
        check_out(1'b0, "R2 expiry after collision");
        run_ticks(250);
    endtask

    task automatic t_disable();
        @(negedge clk);
        wd_sel = 2'b11;
        run_ticks(2000);
        check_out(1'b1, "R6 off setting");
        wd_sel = 2'b10;
        idle_cycles(2);
        run_ticks(249);
        check_out(1'b1, "R6 reload on enable");
        run_ticks(1);
        check_out(1'b0, "R6 expiry after enable");
        batt_mode = 1'b1;
        idle_cycles(1);
        check_out(1'b1, "R6 battery releases pulse");
        run_ticks(2000);
        check_out(1'b1, "R6 battery no reset");
        batt_mode = 1'b0;
        idle_cycles(2);
        run_ticks(249);
        check_out(1'b1, "R6 reload after battery");
        run_ticks(1);
        check_out(1'b0, "R6 expiry after battery");
        run_ticks(250);
    endtask

    initial begin
        t_reset();
        t_long_and_pulse();
        t_sel(2'b01, 750, "R3 mid period");
        t_sel(2'b10, 250, "R3 short period");
        t_sel_change();
        t_refresh();
        t_start_in_pulse();
        t_not_start();
        t_coincide();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule